// File: doc/BRIEF.md
# Egress VLAN Tag Resolver

For every frame leaving a switch port, this block decides whether the frame leaves untagged or keeps the tagging it had on arrival. It also decides whether a link-local control frame is trapped to the CPU port. Frame metadata enters with a valid/ready handshake. The metadata carries the destination MAC, EtherType, ingress tag state, source and destination ports, and the tag fields that the address-table and VLAN-table lookups have already returned. One clock later the block presents the resolved tag mode, the configuration level that decided it, the trap flag and the effective egress port.

The block first sorts each frame into a control class, using its destination address and EtherType. It then walks five tag sources and takes the first one that holds a recognised value:

1. The class register.
2. The address-table entry.
3. The ingress-port setting.
4. The VLAN-table entry for the outgoing port.
5. The egress-port default.

A trapped frame is steered to the CPU port, so the egress-port default is taken from the CPU port. Configuration is written through an address/data/write-enable port.

Top module: `vtag_egress_resolver`

## Requirements
- R1: After reset all configuration fields are zero, `out_valid` is low and `in_ready` is high; a frame then resolves to mode 4 (untagged) at level 5.
- R2: The tag mode is taken from the first source whose field is set. The sources are checked in this order, and `out_level` reports the one that won: class register (level 0), `in_addr_tag` (1), ingress-port tag of `in_src_port` (2), `in_vlan_tag` (3), egress-port tag of the effective egress port (4).
- R3: A field counts as set only when it holds 1 (consistent) or 4 (untagged). Any other value falls through to the next source. When no source is set, the result is mode 4 at level 5, so `out_mode` is always 1 or 4.
- R4: `out_tagged` is high only when the resolved mode is 1 and the frame arrived tagged (`in_tagged`). Under mode 4 it is always low.
- R5: A frame whose DA is 01:80:C2:00:00:xx with xx at most 0x2F is reserved. Its class is chosen as follows:
  - xx = 00 gives BPDU (class 0).
  - Otherwise, EtherType 0x888E gives PAE (class 1), taking precedence over the reserved suffixes.
  - Otherwise, xx of 01, 02, 03, 0E, 10, 20 or 21 gives classes 2 to 8 in that order.
  - Any other reserved xx gives the catch-all class 9.
  - A DA with xx above 0x2F is not reserved.
- R6: Frames that are not reserved are classified by EtherType and address:
  - EtherType 0x8863 gives PPPoE discovery (class 10).
  - EtherType 0x0806 or 0x8035 gives ARP/RARP (class 11).
  - DA 01:00:5E:xx:xx:xx with EtherType 0x0800 gives IGMP (class 12).
  - DA 33:33:xx:xx:xx:xx with EtherType 0x86DD gives MLD (class 13).
  - Anything else has no class and skips level 0.
- R7: Configuration word `a`, for `a` from 0 to 6, sets class 2a and class 2a+1:
  - Class 2a takes its tag from bits 8:6 and its forward mode from bits 2:0.
  - Class 2a+1 takes its tag from bits 24:22 and its forward mode from bits 18:16.
  - Address 8+p writes the ingress tag of port p from bits 2:0.
  - Address 16+p writes the egress tag of port p from bits 2:0.
  - A write to any other address changes nothing.
- R8: A classified frame whose class forward mode is 6 (CPU only) has `out_trap` high. For such a frame `out_port` is `CPU_PORT`, and level 4 uses the CPU port's egress tag. For any other frame `out_port` is `in_dst_port`.
- R9: The ingress-port level is indexed by `in_src_port` and the egress-port level by the effective egress port, never the other way round.
- R10: A frame accepted at a clock edge is presented on the outputs at that edge and held stable while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`. A configuration write and a frame accepted on the same edge resolve against the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Frame metadata valid |
| in_ready | output | 1 | Block can accept metadata |
| in_da | input | 48 | Destination MAC address |
| in_etype | input | 16 | EtherType |
| in_tagged | input | 1 | Frame arrived VLAN-tagged |
| in_src_port | input | PW | Ingress port |
| in_dst_port | input | PW | Egress port from forwarding |
| in_addr_tag | input | 3 | Tag field of the matching address-table entry |
| in_vlan_tag | input | 3 | VLAN-table tag field for the outgoing port |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_mode | output | 3 | Resolved tag mode (1 consistent, 4 untagged) |
| out_level | output | 3 | Winning source level (0 to 4, 5 = none) |
| out_tagged | output | 1 | Frame leaves with a VLAN tag |
| out_trap | output | 1 | Frame trapped to the CPU port |
| out_port | output | PW | Effective egress port |

## Verification
Several properties are checked on every cycle by the assertions:
- The result stays stable under backpressure.
- `out_mode` is always 1 or 4, and an empty chain always yields untagged.
- An untagged result never reports a VLAN tag.
- A trapped frame always names the CPU port.

Only the bench scenarios can show the rest: that the right level wins when several sources are set, that each DA and EtherType lands in its class, that each register field sits at the bit position stated, and that the two port tables use the correct port. The bench covers these with directed frames and a long randomised run.

// File: rtl/vtag_egress_resolver.sv
module vtag_egress_resolver #(
  parameter int NPORT    = 7,
  parameter int CPU_PORT = 6,
  parameter int PW       = $clog2(NPORT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [47:0]   in_da,
  input  logic [15:0]   in_etype,
  input  logic          in_tagged,
  input  logic [PW-1:0] in_src_port,
  input  logic [PW-1:0] in_dst_port,
  input  logic [2:0]    in_addr_tag,
  input  logic [2:0]    in_vlan_tag,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_mode,
  output logic [2:0]    out_level,
  output logic          out_tagged,
  output logic          out_trap,
  output logic [PW-1:0] out_port
);
  localparam int NCLS   = 14;
  localparam int NSLOT  = 1 << PW;
  localparam logic [2:0] M_CONS = 3'd1;
  localparam logic [2:0] M_UNTG = 3'd4;
  localparam logic [2:0] FW_CPU = 3'd6;

  logic [2:0] ctag [16];
  logic [2:0] cfwd [16];
  logic [2:0] itag [NSLOT];
  logic [2:0] etag [NSLOT];

  // configuration store
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin ctag[i] <= '0; cfwd[i] <= '0; end
      for (int p = 0; p < NSLOT; p++) begin itag[p] <= '0; etag[p] <= '0; end
    end else if (cfg_we) begin
      if (cfg_addr[4:3] == 2'd0 && cfg_addr[2:0] != 3'd7) begin
        ctag[{cfg_addr[2:0], 1'b0}] <= cfg_wdata[8:6];
        cfwd[{cfg_addr[2:0], 1'b0}] <= cfg_wdata[2:0];
        ctag[{cfg_addr[2:0], 1'b1}] <= cfg_wdata[24:22];
        cfwd[{cfg_addr[2:0], 1'b1}] <= cfg_wdata[18:16];
      end
      if (cfg_addr[4:3] == 2'd1 && int'(cfg_addr[2:0]) < NPORT)
        itag[cfg_addr[PW-1:0]] <= cfg_wdata[2:0];
      if (cfg_addr[4:3] == 2'd2 && int'(cfg_addr[2:0]) < NPORT)
        etag[cfg_addr[PW-1:0]] <= cfg_wdata[2:0];
    end
  end

  // frame classification
  logic       rsv;
  logic [3:0] cls;
  assign rsv = (in_da[47:8] == 40'h0180C20000) && (in_da[7:0] <= 8'h2F);

  always_comb begin
    cls = 4'(NCLS);
    if (rsv && in_da[7:0] == 8'h00)      cls = 4'd0;
    else if (rsv && in_etype == 16'h888E) cls = 4'd1;
    else if (rsv) begin
      case (in_da[7:0])
        8'h01:   cls = 4'd2;
        8'h02:   cls = 4'd3;
        8'h03:   cls = 4'd4;
        8'h0E:   cls = 4'd5;
        8'h10:   cls = 4'd6;
        8'h20:   cls = 4'd7;
        8'h21:   cls = 4'd8;
        default: cls = 4'd9;
      endcase
    end
    else if (in_etype == 16'h8863)                          cls = 4'd10;
    else if (in_etype == 16'h0806 || in_etype == 16'h8035)  cls = 4'd11;
    else if (in_da[47:24] == 24'h01005E && in_etype == 16'h0800) cls = 4'd12;
    else if (in_da[47:32] == 16'h3333 && in_etype == 16'h86DD)   cls = 4'd13;
  end

  // priority chain
  logic          trap;
  logic [PW-1:0] eport;
  logic [2:0]    t0, t2, t4, mode, level;
  assign trap  = (cfwd[cls] == FW_CPU);
  assign eport = trap ? PW'(CPU_PORT) : in_dst_port;
  assign t0    = ctag[cls];
  assign t2    = itag[in_src_port];
  assign t4    = etag[eport];

  function automatic logic is_set(input logic [2:0] t);
    return (t == M_CONS) || (t == M_UNTG);
  endfunction

  always_comb begin
    if      (is_set(t0))          begin mode = t0;          level = 3'd0; end
    else if (is_set(in_addr_tag)) begin mode = in_addr_tag; level = 3'd1; end
    else if (is_set(t2))          begin mode = t2;          level = 3'd2; end
    else if (is_set(in_vlan_tag)) begin mode = in_vlan_tag; level = 3'd3; end
    else if (is_set(t4))          begin mode = t4;          level = 3'd4; end
    else                          begin mode = M_UNTG;      level = 3'd5; end
  end

  // output register with handshake
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_mode   <= M_UNTG;
      out_level  <= 3'd5;
      out_tagged <= 1'b0;
      out_trap   <= 1'b0;
      out_port   <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_mode   <= mode;
      out_level  <= level;
      out_tagged <= (mode == M_CONS) && in_tagged;
      out_trap   <= trap;
      out_port   <= eport;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mode) && $stable(out_level)
      && $stable(out_trap) && $stable(out_port) && $stable(out_tagged)); // R10
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode == M_CONS || out_mode == M_UNTG)); // R3
  AST_EMPTY_UNTAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_level == 3'd5 |-> out_mode == M_UNTG); // R3
  AST_UNTAGGED_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode == M_UNTG |-> !out_tagged); // R4
  AST_TRAP_TO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap |-> out_port == PW'(CPU_PORT)); // R8
endmodule

// File: tb/vtag_egress_resolver_bench.sv
module vtag_egress_resolver_bench;
  localparam int NPORT = 7;
  localparam int CPU   = 6;
  localparam int PW    = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [4:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic in_valid = 0, in_ready, in_tagged = 0;
  logic [47:0] in_da = 0; logic [15:0] in_etype = 0;
  logic [PW-1:0] in_src_port = 0, in_dst_port = 0;
  logic [2:0] in_addr_tag = 0, in_vlan_tag = 0;
  logic out_valid, out_ready = 1, out_tagged, out_trap;
  logic [2:0] out_mode, out_level; logic [PW-1:0] out_port;

  vtag_egress_resolver #(.NPORT(NPORT), .CPU_PORT(CPU), .PW(PW)) u_vtag_egress_resolver (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int bct[16], bcf[16], bit_[8], bet[8];
  int q_mode[$], q_lvl[$], q_tg[$], q_trap[$], q_port[$];
  string q_req[$];
  string cur_req = "R1";
  bit rnd_ready = 0;

  function automatic int classify(logic [47:0] da, logic [15:0] et);
    int suf = da[7:0];
    bit r = (da[47:8] == 40'h0180C20000) && (suf <= 47);
    int list[7] = '{1, 2, 3, 14, 16, 32, 33};
    if (r) begin
      if (suf == 0) return 0;
      if (et == 16'h888E) return 1;
      foreach (list[i]) if (list[i] == suf) return 2 + i;
      return 9;
    end
    if (et == 16'h8863) return 10;
    if (et == 16'h0806 || et == 16'h8035) return 11;
    if (da[47:24] == 24'h01005E && et == 16'h0800) return 12;
    if (da[47:32] == 16'h3333 && et == 16'h86DD) return 13;
    return -1;
  endfunction

  task automatic expect_push();
    int c = classify(in_da, in_etype);
    int trp = (c >= 0 && bcf[c] == 6) ? 1 : 0;
    int ep = trp ? CPU : int'(in_dst_port);
    int src[5];
    int m = 4, l = 5;
    src[0] = (c >= 0) ? bct[c] : 0;
    src[1] = in_addr_tag; src[2] = bit_[in_src_port]; src[3] = in_vlan_tag; src[4] = bet[ep];
    for (int k = 4; k >= 0; k--) if (src[k] == 1 || src[k] == 4) begin m = src[k]; l = k; end
    q_mode.push_back(m); q_lvl.push_back(l); q_trap.push_back(trp); q_port.push_back(ep);
    q_tg.push_back((m == 1 && in_tagged) ? 1 : 0); q_req.push_back(cur_req);
  endtask

  task automatic chk(string req, int act, int exp, string what);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R10", in_ready, (!out_valid || out_ready), "in_ready");
    if (out_valid) begin
      if (q_mode.size() == 0) chk("R10", 1, 0, "unexpected out_valid");
      else begin
        chk(q_req[0], out_mode, q_mode[0], "mode");
        chk(q_req[0], out_level, q_lvl[0], "level");
        chk(q_req[0], out_tagged, q_tg[0], "tagged");
        chk(q_req[0], out_trap, q_trap[0], "trap");
        chk(q_req[0], out_port, q_port[0], "port");
        if (out_ready) begin
          void'(q_mode.pop_front()); void'(q_lvl.pop_front()); void'(q_tg.pop_front());
          void'(q_trap.pop_front()); void'(q_port.pop_front()); void'(q_req.pop_front());
        end
      end
    end
    if (in_valid && in_ready) expect_push();
    if (cfg_we) begin
      if (cfg_addr < 7) begin
        bct[2*cfg_addr] = cfg_wdata[8:6];     bcf[2*cfg_addr] = cfg_wdata[2:0];
        bct[2*cfg_addr+1] = cfg_wdata[24:22]; bcf[2*cfg_addr+1] = cfg_wdata[18:16];
      end
      if (cfg_addr >= 8 && cfg_addr < 8 + NPORT) bit_[cfg_addr-8] = cfg_wdata[2:0];
      if (cfg_addr >= 16 && cfg_addr < 16 + NPORT) bet[cfg_addr-16] = cfg_wdata[2:0];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (rnd_ready) begin #2 out_ready = ($urandom_range(0, 3) != 0); end
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic cfg(int a, logic [31:0] d);
    @(posedge clk); #2 cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = d;
    @(posedge clk); #2 cfg_we = 0;
  endtask

  task automatic send(string req, logic [47:0] da, logic [15:0] et, bit tg,
                      int s, int d, int at, int vt);
    @(posedge clk); #2;
    cur_req = req; in_valid = 1; in_da = da; in_etype = et; in_tagged = tg;
    in_src_port = PW'(s); in_dst_port = PW'(d); in_addr_tag = 3'(at); in_vlan_tag = 3'(vt);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2 in_valid = 0;
  endtask

  localparam logic [47:0] UNI = 48'h0200_0000_0001;
  localparam logic [47:0] RSV = 48'h0180_C200_0000;

  initial begin
    foreach (bct[i]) begin bct[i] = 0; bcf[i] = 0; end
    foreach (bit_[i]) begin bit_[i] = 0; bet[i] = 0; end
    #1;
    chk("R1", out_valid, 0, "out_valid in reset");
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R1", in_ready, 1, "in_ready after reset");
    send("R1", UNI, 16'h0800, 1, 0, 1, 0, 0);
    send("R3", UNI, 16'h0800, 1, 0, 1, 2, 7);            // unset values fall through
    cfg(16 + 2, 1);                                        // R9 egress port 2 consistent
    send("R4", UNI, 16'h0800, 1, 0, 2, 0, 0);
    send("R4", UNI, 16'h0800, 0, 0, 2, 0, 0);
    send("R9", UNI, 16'h0800, 1, 2, 0, 0, 0);             // src 2 must not use egress table
    cfg(8 + 3, 4);                                         // ingress port 3 untagged
    send("R9", UNI, 16'h0800, 1, 3, 2, 0, 0);
    send("R2", UNI, 16'h0800, 1, 3, 2, 1, 0);             // address table beats ingress
    send("R2", UNI, 16'h0800, 1, 0, 2, 0, 4);             // vlan beats egress
    send("R2", UNI, 16'h0800, 1, 3, 2, 0, 1);             // ingress beats vlan
    cfg(0, (32'd1 << 22) | (32'd0 << 16) | (32'd4 << 6) | 32'd6);   // R7 BPDU/PAE word
    send("R8", RSV, 16'h0026, 1, 1, 2, 1, 1);             // BPDU trapped, untagged
    send("R5", RSV | 48'h03, 16'h888E, 1, 1, 2, 4, 4);    // PAE wins over suffix 03
    cfg(2, (32'd4 << 22) | (32'd6 << 16));                // R7 0E in high half
    send("R7", RSV | 48'h0E, 16'h88CC, 1, 1, 2, 1, 1);
    send("R5", RSV | 48'h03, 16'h0800, 1, 0, 2, 0, 0);    // suffix 03 unset
    cfg(16 + CPU, 1);
    cfg(2, (32'd2 << 22) | (32'd6 << 16));                // trap with unset tag
    send("R8", RSV | 48'h0E, 16'h88CC, 1, 0, 2, 0, 0);
    cfg(4, (32'd4 << 22) | (32'd1 << 6));                 // R21 lo, catch-all hi
    send("R5", RSV | 48'h21, 16'h0800, 1, 0, 1, 0, 0);
    send("R5", RSV | 48'h05, 16'h0800, 1, 0, 1, 0, 0);
    send("R5", RSV | 48'h30, 16'h0800, 1, 0, 1, 0, 0);    // not reserved
    cfg(5, (32'd1 << 22) | (32'd4 << 6));                 // PPPoE lo, ARP hi
    cfg(6, (32'd4 << 22) | (32'd1 << 6));                 // IGMP lo, MLD hi
    send("R6", UNI, 16'h8863, 1, 0, 1, 0, 0);
    send("R6", UNI, 16'h8035, 1, 0, 1, 0, 0);
    send("R6", 48'h0100_5E00_0016, 16'h0800, 1, 0, 1, 0, 0);
    send("R6", 48'h3333_0000_0016, 16'h86DD, 1, 0, 1, 0, 0);
    send("R6", 48'h3333_0000_0016, 16'h0800, 1, 0, 1, 0, 0);
    cfg(7, 32'hFFFF_FFFF);                                 // unmapped address: no effect
    cfg(15, 32'hFFFF_FFFF);
    send("R7", UNI, 16'h0800, 1, 0, 1, 0, 0);
    // R10 backpressure and same-edge write
    @(posedge clk); #2 out_ready = 0;
    send("R10", UNI, 16'h0800, 1, 0, 2, 0, 0);
    fork send("R10", UNI, 16'h0806, 1, 0, 2, 0, 0); join_none
    repeat (4) @(posedge clk);
    #2 out_ready = 1;
    repeat (4) @(posedge clk);
    @(posedge clk); #2 cfg_we = 1; cfg_addr = 5'd18; cfg_wdata = 32'd4;
    in_valid = 1; cur_req = "R10"; in_da = UNI; in_etype = 16'h0800; in_tagged = 1;
    in_src_port = 0; in_dst_port = 2; in_addr_tag = 0; in_vlan_tag = 0;
    @(posedge clk); #2 cfg_we = 0; in_valid = 0;
    // randomised run
    rnd_ready = 1;
    for (int n = 0; n < 400; n++) begin
      logic [47:0] das[5];
      logic [15:0] ets[6];
      das = '{UNI, RSV, RSV | 48'h0E, 48'h0100_5E00_0001, 48'h3333_0000_0001};
      ets = '{16'h0800, 16'h888E, 16'h8863, 16'h0806, 16'h86DD, 16'h8035};
      if ($urandom_range(0, 3) == 0)
        cfg($urandom_range(0, 23), $urandom);
      send("R2", das[$urandom_range(0, 4)] | 48'($urandom_range(0, 3)), ets[$urandom_range(0, 5)],
           1'($urandom), $urandom_range(0, NPORT - 1), $urandom_range(0, NPORT - 1),
           $urandom_range(0, 7), $urandom_range(0, 7));
    end
    rnd_ready = 0;
    @(posedge clk); #2 out_ready = 1;
    repeat (6) @(posedge clk);
    chk("R10", q_mode.size(), 0, "queue drained");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule